// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the station-management master of an Ethernet MAC. Software loads one 32-bit frame word that carries the start code, opcode, PHY address, register address, turnaround code and 16-bit data. That single write launches the transaction. The block sends a 32-bit preamble of ones and then the frame, most significant bit first, on the MDC/MDIO pair. On a read frame it releases the data line at the turnaround and captures the PHY's 16 data bits into the data field of the same frame word. Software reads the result from there.

MDC is produced by dividing the system clock with a programmable divisor. The point at which MDIO changes after each MDC falling edge is delayed by a separately programmed hold count, measured in system clocks. When the frame finishes, a sticky completion flag is set in the event register. Software clears the flag by writing one to it before it starts the next frame.

The register map has three words: frame at address 0, clock control at address 1, event at address 2.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After synchronous reset, MDC is low, the MDIO output enable is low, and all three registers read zero.
- R2: The divisor D sits in clock-control bits [7:0]. While a frame runs with D nonzero, MDC starts low, first rises D+1 clocks after the launch, and keeps each high and low phase for D+1 clocks. With D = 0, MDC holds its level and the frame stalls. The frame resumes once D becomes nonzero.
- R3: The frame word layout is [31:30] start, [29:28] opcode, [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data. A frame is 32 ones followed by frame bits 31 down to 0. Each bit is the MDIO value present when MDC rises, and 64 rising edges occur per frame.
- R4: The hold field is clock-control bits [11:8]. Call it H, and let Heff = min(H, D). While MDIO is driven, the output changes only Heff clocks after an MDC falling edge, and never while MDC is high.
- R5: A frame whose opcode is not 10 drives MDIO during all 64 bits. The output enable drops, and MDC stays low, at the MDC falling edge that ends the last bit.
- R6: A frame with opcode 10 is a read. The output enable is released, with the MDIO output held low, from the first turnaround bit (frame bit 17) to the end of the frame. The value of the PHY's input line is sampled at the 16 rising edges of the data phase and stored in frame bits [15:0], the first sample in bit 15.
- R7: Event register bit 0 sets when a frame ends and stays set. Writing 1 to bit 0 clears it. Writing 0 has no effect.
- R8: A write to the frame register while a frame runs is ignored. The frame in flight and the frame register contents do not change, and no new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address: 0 frame, 1 clock control, 2 event |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address, same map |
| reg_rdata | output | 32 | Read data, combinational from the registers |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
The hardest situation to reach is the read data phase. The PHY must present each data bit between an MDC falling edge and the next rising edge, and the block must catch it on exactly the right rising edge. The bench models the PHY from the MDC edges it observes: it counts rising edges and drives the matching bit of a chosen data word after each falling edge. The captured word is then compared through the frame register. A second hard case is a frame-register write landing mid-frame. The stimulus issues that write about a hundred clocks into a slow frame and then compares the complete bit stream against the first frame.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants for the management frame controller: register addresses,
// frame geometry and the opcode that marks a read.
package mdio_mgmt_pkg;
    localparam int FRAME_W       = 32;
    localparam int PREAMBLE_LEN  = 32;
    localparam int TOTAL_BITS    = PREAMBLE_LEN + FRAME_W;
    localparam int IDX_W         = $clog2(TOTAL_BITS);
    // Serial index of the first turnaround bit and of the first data bit
    localparam int TA_FIRST_BIT   = PREAMBLE_LEN + 14;
    localparam int DATA_FIRST_BIT = PREAMBLE_LEN + 16;
    // Opcode field position and the read code
    localparam int OP_MSB = 29;
    localparam int OP_LSB = 28;
    localparam logic [1:0] OP_READ = 2'b10;
    // Hold field position inside the clock-control word
    localparam int HOLD_LSB = 8;
    // Register addresses
    localparam logic [1:0] ADDR_FRAME  = 2'd0;
    localparam logic [1:0] ADDR_CLKCTL = 2'd1;
    localparam logic [1:0] ADDR_EVENT  = 2'd2;
endpackage

// File: rtl/mdio_clk_gen.sv
// MDC generator. Divides the system clock so that each MDC phase lasts
// div+1 clocks while run is high. Assumes MDC is low whenever run rises,
// which holds because a frame ends on a falling edge. div = 0 freezes MDC.
// The tick outputs flag the cycle whose closing edge moves MDC.
module mdio_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    // Phase end: counter reached the divisor (>= survives a lowered divisor)
    always_comb begin
        tick      = run && (div != '0) && (cnt >= div);
        rise_tick = tick && !mdc;
        fall_tick = tick && mdc;
    end

    // Phase counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run || div == '0) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MDC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> $stable(mdc)); // R2

endmodule

// File: rtl/mdio_frame_shifter.sv
// Frame sequencer. Holds the frame word, walks the 64 serial positions
// (preamble then frame), and updates MDIO a clamped hold count after each
// MDC falling edge. On read frames it releases the line at the turnaround
// and shifts sampled PHY bits into the low 16 bits of the frame word.
// Assumes launch is only raised while idle.
module mdio_frame_shifter
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [DIV_W-1:0]   div,
    input  logic [HOLD_W-1:0]  hold_cfg,
    input  logic               mdc,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done_pulse,
    output logic [FRAME_W-1:0] frame_q
);
    localparam int CW = (DIV_W > HOLD_W) ? DIV_W : HOLD_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BITS - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] nidx;
    logic [CW-1:0]    hcnt;
    logic [CW-1:0]    eff_hold;
    logic             pend;
    logic             is_read;
    logic             nbit;
    logic             noe;
    logic             last_fall;
    logic             advance;

    // Hold clamp, next-position bit value and enable, and step decision
    always_comb begin
        eff_hold  = (CW'(hold_cfg) > CW'(div)) ? CW'(div) : CW'(hold_cfg);
        nidx      = idx + 1'b1;
        noe       = !(is_read && nidx >= IDX_W'(TA_FIRST_BIT));
        nbit      = nidx[IDX_W-1] ? frame_q[~nidx[IDX_W-2:0]] : 1'b1;
        last_fall = busy && fall_tick && (idx == LAST_IDX);
        advance   = busy && !last_fall &&
                    ((fall_tick && eff_hold == '0) ||
                     (pend && !fall_tick && hcnt >= eff_hold));
        done_pulse = last_fall;
    end

    // Frame state, serial position, hold delay and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            busy    <= 1'b0;
            idx     <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            is_read <= 1'b0;
            pend    <= 1'b0;
            hcnt    <= '0;
        end else if (launch) begin
            frame_q <= frame_in;
            busy    <= 1'b1;
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
            is_read <= (frame_in[OP_MSB:OP_LSB] == OP_READ);
            pend    <= 1'b0;
            hcnt    <= '0;
        end else if (busy) begin
            if (rise_tick && is_read && idx >= IDX_W'(DATA_FIRST_BIT))
                frame_q[15:0] <= {frame_q[14:0], mdio_i};
            if (last_fall) begin
                busy    <= 1'b0;
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b0;
                pend    <= 1'b0;
            end else if (advance) begin
                idx     <= nidx;
                mdio_o  <= noe & nbit;
                mdio_oe <= noe;
                pend    <= 1'b0;
            end else if (fall_tick) begin
                pend <= 1'b1;
                hcnt <= CW'(1);
            end else if (pend) begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe); // R5
    AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_read && idx >= IDX_W'(TA_FIRST_BIT)) |-> !mdio_oe); // R6
    AST_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mdc && !fall_tick) |=> $stable(mdio_o)); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !busy); // R7

endmodule

// File: rtl/mdio_mgmt_master.sv
// Management frame controller top. Decodes the three-word register map,
// keeps the clock-control word and the sticky completion flag, and ties
// the MDC generator to the frame sequencer. A frame write is accepted only
// while idle. Assumes DIV_W <= HOLD_LSB so the two control fields do not overlap.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [DIV_W-1:0]   div_q;
    logic [HOLD_W-1:0]  hold_q;
    logic               done_q;
    logic               busy;
    logic               done_pulse;
    logic               rise_tick;
    logic               fall_tick;
    logic [FRAME_W-1:0] frame_q;
    logic               frame_wr;
    logic               ctl_wr;
    logic               evt_wr;
    logic               launch;

    // Write decode; frame writes while busy never launch
    always_comb begin
        frame_wr = reg_wr && (reg_waddr == ADDR_FRAME);
        ctl_wr   = reg_wr && (reg_waddr == ADDR_CLKCTL);
        evt_wr   = reg_wr && (reg_waddr == ADDR_EVENT);
        launch   = frame_wr && !busy;
    end

    // Clock-control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            hold_q <= '0;
        end else if (ctl_wr) begin
            div_q  <= reg_wdata[DIV_W-1:0];
            hold_q <= reg_wdata[HOLD_LSB +: HOLD_W];
        end
    end

    // Sticky completion flag, set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (done_pulse)
            done_q <= 1'b1;
        else if (evt_wr && reg_wdata[0])
            done_q <= 1'b0;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            ADDR_FRAME:  reg_rdata = frame_q;
            ADDR_CLKCTL: begin
                reg_rdata[DIV_W-1:0]          = div_q;
                reg_rdata[HOLD_LSB +: HOLD_W] = hold_q;
            end
            ADDR_EVENT:  reg_rdata[0] = done_q;
            default:     reg_rdata = '0;
        endcase
    end

    mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_shifter #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_shf (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .frame_in   (reg_wdata),
        .div        (div_q),
        .hold_cfg   (hold_q),
        .mdc        (mdc),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mdio_i     (mdio_i),
        .busy       (busy),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done_pulse (done_pulse),
        .frame_q    (frame_q)
    );

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_wr && busy) |=> (frame_q[31:16] == $past(frame_q[31:16]))); // R8
    AST_EVENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> done_q); // R7

endmodule

// File: tb/mdio_mgmt_master_test.sv
// Bench: behavioural PHY-side observer with queues, checked on every clock.
module mdio_mgmt_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    always #4 clk = ~clk;

    mdio_mgmt_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int vectors = 0;
    int miscompares = 0;

    // Observer state
    bit          frame_act = 0;
    bit          chk_period = 0;
    bit          seen_fall = 0;
    int          since_tog = 0;
    int          since_fall = 0;
    int          rises = 0;
    int          exp_half = 1;
    int          exp_hold = 0;
    logic [15:0] phy_word = '0;
    logic        bits_q[$];
    logic        oe_q[$];
    logic        prev_mdc = 1'b0, prev_mdio = 1'b0, prev_oe = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock observer and PHY model, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mdio_oe && !prev_oe && !frame_act) begin
                frame_act = 1; since_tog = 0; since_fall = 0;
                seen_fall = 0; rises = 0;
            end else if (frame_act) begin
                since_tog++; since_fall++;
            end
            if (frame_act && mdc !== prev_mdc) begin
                if (chk_period) check("R2", "mdc phase length", since_tog, exp_half);
                since_tog = 0;
                if (mdc) begin
                    bits_q.push_back(mdio_o);
                    oe_q.push_back(mdio_oe);
                    rises++;
                end else begin
                    since_fall = 0; seen_fall = 1;
                    if (rises >= 48 && rises <= 63) mdio_i = phy_word[63-rises];
                    else mdio_i = 1'b0;
                end
            end
            if (frame_act && seen_fall && mdio_oe && prev_oe && mdio_o !== prev_mdio)
                check("R4", "mdio change delay after mdc fall", since_fall, exp_hold);
        end
        prev_mdc = mdc; prev_mdio = mdio_o; prev_oe = mdio_oe;
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_raddr = a; #1; d = reg_rdata;
    endtask

    task automatic set_clk(input int d, input int h);
        wr(2'd1, (h << 8) | d);
        exp_half = d + 1;
        exp_hold = (h > d) ? d : h;
    endtask

    task automatic launch(input logic [31:0] f);
        bits_q.delete(); oe_q.delete(); frame_act = 0;
        wr(2'd0, f);
    endtask

    task automatic wait_done();
        logic [31:0] e;
        int n = 0;
        do begin tick(); rd(2'd2, e); n++; end while (e[0] == 1'b0 && n < 20000);
    endtask

    task automatic check_frame(input logic [31:0] f, input logic [15:0] rdv, input string wreq);
        logic [31:0] x;
        bit isrd = (f[29:28] == 2'b10);
        check("R3", "rising edge count", bits_q.size(), 64);
        for (int i = 0; i < 64 && i < bits_q.size(); i++) begin
            logic eb = (i < 32) ? 1'b1 : ((isrd && i >= 46) ? 1'b0 : f[63-i]);
            logic eo = !(isrd && i >= 46);
            check((isrd && i >= 46) ? "R6" : "R3", $sformatf("bit %0d", i), bits_q[i], eb);
            check(isrd ? "R6" : "R5", $sformatf("enable at bit %0d", i), oe_q[i], eo);
        end
        check("R5", "enable after frame", mdio_oe, 0);
        check("R5", "mdc after frame", mdc, 0);
        rd(2'd0, x);
        check(isrd ? "R6" : wreq, "frame readback", x, isrd ? {f[31:16], rdv} : f);
        rd(2'd2, x);
        check("R7", "event set at end", x, 1);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R7 watchdog: actual no completion expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] x;
        logic [31:0] fa;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1", "mdc after reset", mdc, 0);
        check("R1", "enable after reset", mdio_oe, 0);
        for (int a = 0; a < 3; a++) begin
            rd(a[1:0], x);
            check("R1", $sformatf("register %0d after reset", a), x, 0);
        end
        chk_period = 1;

        // Write frame, divisor 3, hold 1
        set_clk(3, 1);
        rd(2'd1, x);
        check("R2", "clock control readback", x, 32'h0000_0103);
        launch({2'b01, 2'b01, 5'h05, 5'h1A, 2'b10, 16'h3C96});
        wait_done();
        check_frame({2'b01, 2'b01, 5'h05, 5'h1A, 2'b10, 16'h3C96}, 16'h0, "R3");
        // R7 write-zero has no effect, write-one clears
        wr(2'd2, 32'h0);
        rd(2'd2, x);
        check("R7", "event after writing 0", x, 1);
        wr(2'd2, 32'h1);
        rd(2'd2, x);
        check("R7", "event after writing 1", x, 0);

        // Read frame, divisor 2, hold 0
        set_clk(2, 0);
        phy_word = 16'hA5C3;
        launch({2'b01, 2'b10, 5'h11, 5'h02, 2'b00, 16'h0000});
        wait_done();
        check_frame({2'b01, 2'b10, 5'h11, 5'h02, 2'b00, 16'h0000}, 16'hA5C3, "R6");
        wr(2'd2, 32'h1);

        // Hold clamp: hold 7 with divisor 2 behaves as hold 2
        set_clk(2, 7);
        launch({2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'h5AF0});
        wait_done();
        check_frame({2'b01, 2'b01, 5'h1F, 5'h00, 2'b10, 16'h5AF0}, 16'h0, "R4");
        wr(2'd2, 32'h1);

        // Fastest MDC, read with a sparse data word
        set_clk(1, 0);
        phy_word = 16'h8001;
        launch({2'b01, 2'b10, 5'h00, 5'h1F, 2'b00, 16'hFFFF});
        wait_done();
        check_frame({2'b01, 2'b10, 5'h00, 5'h1F, 2'b00, 16'hFFFF}, 16'h8001, "R6");
        wr(2'd2, 32'h1);

        // R8 frame write during a running frame is ignored
        set_clk(4, 2);
        fa = {2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h1234};
        launch(fa);
        repeat (100) tick();
        wr(2'd0, {2'b01, 2'b10, 5'h15, 5'h0A, 2'b00, 16'hEDCB});
        rd(2'd0, x);
        check("R8", "frame register during busy write", x, fa);
        wait_done();
        check_frame(fa, 16'h0, "R8");
        repeat (20) tick();
        check("R8", "no second frame started", mdio_oe, 0);
        wr(2'd2, 32'h1);

        // R2 divisor 0 stalls the frame, a nonzero divisor resumes it
        chk_period = 0;
        set_clk(0, 0);
        launch({2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h00FF});
        repeat (40) tick();
        check("R2", "mdc frozen with divisor 0", mdc, 0);
        rd(2'd2, x);
        check("R2", "no completion while stalled", x, 0);
        set_clk(1, 1);
        wait_done();
        check_frame({2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h00FF}, 16'h0, "R2");
        chk_period = 1;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule